// File: doc/BRIEF.md
# Clock-Activity Sleep/Wake Detector

This block watches an incoming bit clock from the side of a slow, free-running local oscillator and decides whether the device should be awake. It brings the bit clock into the local domain through a two-flop synchronizer. It counts rising edges over fixed measurement windows of the local clock. Each window's total is compared against two separate thresholds: a high wake point and a low sleep point. A total between the two points keeps the current state. This gives hysteresis, so a clock near one boundary cannot make the state chatter.

The wake decision needs several consecutive fast windows, so a short burst of clock edges cannot wake the part. The sleep decision takes effect on the first slow window. A stopped clock, held either high or low, counts as slow. The block drives an active flag and a separate output-enable for the data driver. While the detector is asleep, the data driver stays disabled. After reset the detector is asleep.

Top module: `clk_activity_detector`

## Requirements
- R1: After reset, `active_o` and `data_oe_o` are both 0.
- R2: `data_oe_o` always equals `active_o`. The data driver is therefore disabled whenever the detector is asleep.
- R3: Only rising transitions of the two-flop-synchronized `bclk_i` are counted, in windows of `WIN_LEN` local cycles. A bit clock held constant at either level counts zero. An edge seen in the cycle that closes a window belongs to that window.
- R4: A window whose total is at least `WAKE_MIN` is a fast window. After `WAKE_WINS` consecutive fast windows, `active_o` rises. With a steady fast bit clock this happens no later than (`WAKE_WINS`+1)·`WIN_LEN`+8 cycles after the clock starts.
- R5: `active_o` does not rise earlier than (`WAKE_WINS`-1)·`WIN_LEN` cycles after a fast clock starts. A burst that lasts one window length never wakes the detector.
- R6: A window whose total is at most `SLEEP_MAX` drops `active_o` when that window closes. This covers a stopped clock and a slow clock. The fall comes no later than 2·`WIN_LEN`+8 cycles after the clock stops or slows.
- R7: A window total strictly between `SLEEP_MAX` and `WAKE_MIN` leaves `active_o` unchanged and clears any partial run of fast windows.
- R8: `active_o` changes only two cycles after a window closes. Any two of its changes are therefore a whole multiple of `WIN_LEN` cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Monitored bit clock, asynchronous |
| active_o | output | 1 | Detector awake |
| data_oe_o | output | 1 | Output-enable for the data driver |

## Verification
Two events can fall in the same local cycle: the closing of a measurement window and the arrival of a synchronized edge. The design must fold that edge into the closing total and must start the next window from zero. The case is provoked with a bit clock at exactly half the local rate, so every other local cycle carries an edge. The window closes on an edge cycle or an edge-free cycle depending on the phase. The result is judged at the ports, by wake latency staying inside its bounds and by all state changes sitting a whole number of windows apart.

// File: rtl/cad_pkg.sv
package cad_pkg;
    typedef enum logic {
        ST_ASLEEP = 1'b0,
        ST_AWAKE  = 1'b1
    } cad_state_e;
endpackage

// File: rtl/cad_sync.sv
module cad_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [2:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[1:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // stages 0 and 1 resolve metastability, stage 2 is history for the edge
    assign rise_o = st_q.pipe[1] & ~st_q.pipe[2];

    p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/cad_rate_meter.sv
module cad_rate_meter #(
    parameter int WIN_LEN = 64,
    localparam int SUM_W  = $clog2(WIN_LEN + 1),
    localparam int WIN_W  = $clog2(WIN_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    output logic             done_o,
    output logic [SUM_W-1:0] sum_o
);
    localparam logic [SUM_W-1:0] SUM_MAX  = SUM_W'(WIN_LEN);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [SUM_W-1:0] edges;
        logic             done;
        logic [SUM_W-1:0] sum;
    } meter_t;

    meter_t st_d, st_q;
    logic [SUM_W-1:0] tally;

    always_comb begin
        st_d  = st_q;
        tally = (rise_i && st_q.edges != SUM_MAX) ? st_q.edges + 1'b1 : st_q.edges;
        st_d.done = (st_q.win == WIN_LAST);
        if (st_q.win == WIN_LAST) begin
            st_d.win   = '0;
            st_d.edges = '0;
            st_d.sum   = tally;  // closing-cycle edge folded in
        end else begin
            st_d.win   = st_q.win + 1'b1;
            st_d.edges = tally;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign sum_o  = st_q.sum;

    // checker: spacing of window closes
    logic [SUM_W:0] gap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     gap_q <= '0;
        else if (done_o) gap_q <= 1;
        else             gap_q <= gap_q + 1'b1;
    end

    p_window_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> gap_q == (SUM_W + 1)'(WIN_LEN));
    p_sum_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sum_o <= SUM_MAX);
endmodule

// File: rtl/cad_state.sv
module cad_state
    import cad_pkg::*;
#(
    parameter int WIN_LEN   = 64,
    parameter int WAKE_MIN  = 20,
    parameter int SLEEP_MAX = 5,
    parameter int WAKE_WINS = 3,
    localparam int SUM_W    = $clog2(WIN_LEN + 1),
    localparam int RUN_W    = $clog2(WAKE_WINS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  logic [SUM_W-1:0] sum_i,
    output logic             active_o,
    output logic             oe_o
);
    localparam logic [RUN_W-1:0] RUN_GOAL = RUN_W'(WAKE_WINS);

    typedef struct packed {
        cad_state_e       state;
        logic [RUN_W-1:0] run;
        logic             oe;
    } ctl_t;

    ctl_t st_d, st_q;
    logic is_fast, is_slow;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        st_d    = st_q;
        is_fast = sum_i >= SUM_W'(WAKE_MIN);
        is_slow = sum_i <= SUM_W'(SLEEP_MAX);
        run_inc = (st_q.run == RUN_GOAL) ? st_q.run : st_q.run + 1'b1;
        if (done_i) begin
            if (is_fast) begin
                st_d.run = run_inc;
                if (run_inc == RUN_GOAL) st_d.state = ST_AWAKE;
            end else begin
                st_d.run = '0;
                if (is_slow) st_d.state = ST_ASLEEP;
            end
        end
        st_d.oe = (st_d.state == ST_AWAKE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{state: ST_ASLEEP, run: '0, oe: 1'b0};
        else         st_q <= st_d;
    end

    assign active_o = (st_q.state == ST_AWAKE);
    assign oe_o     = st_q.oe;

    p_change_on_close_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o != $past(active_o)) |-> $past(done_i));
    p_slow_sleeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && sum_i <= SUM_W'(SLEEP_MAX)) |=> !active_o);
    p_run_wakes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && sum_i >= SUM_W'(WAKE_MIN) && st_q.run == RUN_GOAL - 1'b1) |=> active_o);
    p_mid_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && sum_i > SUM_W'(SLEEP_MAX) && sum_i < SUM_W'(WAKE_MIN))
        |=> (active_o == $past(active_o)) && st_q.run == '0);
endmodule

// File: rtl/clk_activity_detector.sv
module clk_activity_detector #(
    parameter int WIN_LEN   = 64,
    parameter int WAKE_MIN  = 20,
    parameter int SLEEP_MAX = 5,
    parameter int WAKE_WINS = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_i,
    output logic active_o,
    output logic data_oe_o
);
    localparam int SUM_W = $clog2(WIN_LEN + 1);

    logic             rise;
    logic             done;
    logic [SUM_W-1:0] sum;

    cad_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (bclk_i),
        .rise_o  (rise)
    );

    cad_rate_meter #(.WIN_LEN(WIN_LEN)) u_meter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (rise),
        .done_o (done),
        .sum_o  (sum)
    );

    cad_state #(
        .WIN_LEN   (WIN_LEN),
        .WAKE_MIN  (WAKE_MIN),
        .SLEEP_MAX (SLEEP_MAX),
        .WAKE_WINS (WAKE_WINS)
    ) u_state (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .done_i   (done),
        .sum_i    (sum),
        .active_o (active_o),
        .oe_o     (data_oe_o)
    );

    p_oe_tracks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_oe_o == active_o);
    p_reset_asleep_r1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> !active_o && !data_oe_o);
endmodule

// File: tb/sim_clk_activity_detector.sv
module sim_clk_activity_detector;
    localparam int WIN  = 64;
    localparam int RUNS = 3;

    logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0;
    logic active, oe;
    int   checks = 0, errors = 0;
    int   cyc = 0;
    int   half_ns = 0;
    bit   hold_high = 1'b0;
    int   t_rise = 0, t_fall = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always begin
        if (half_ns == 0) begin
            bclk = hold_high;
            #8;
        end else begin
            #(half_ns) bclk = ~bclk;
        end
    end

    clk_activity_detector u0 (
        .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk),
        .active_o(active), .data_oe_o(oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl, input int limit, output int lat);
        lat = 0;
        while (active !== lvl && lat < limit) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(active == 0, "R1 active", active, 0);
        check(oe == 0, "R1 oe", oe, 0);
    endtask

    task automatic t_wake();
        int lat;
        half_ns = 8;
        wait_level(1'b1, 1000, lat);
        t_rise = cyc;
        check(lat <= (RUNS + 1) * WIN + 8, "R4 wake latency max", lat, (RUNS + 1) * WIN + 8);
        check(lat >= (RUNS - 1) * WIN, "R5 wake latency min", lat, (RUNS - 1) * WIN);
        check(oe == 1, "R2 oe awake", oe, 1);
    endtask

    task automatic t_hold_awake();
        half_ns = 16;
        for (int i = 0; i < 5; i++) begin
            repeat (WIN) @(negedge clk);
            check(active == 1, "R7 mid rate keeps awake", active, 1);
        end
    endtask

    task automatic t_sleep(input int hn, input bit hi, input string tag);
        int lat;
        half_ns = hn;
        hold_high = hi;
        wait_level(1'b0, 1000, lat);
        t_fall = cyc;
        check(lat <= 2 * WIN + 8, tag, lat, 2 * WIN + 8);
        check(oe == 0, "R2 oe asleep", oe, 0);
        check((t_fall - t_rise) % WIN == 0, "R8 change spacing", (t_fall - t_rise) % WIN, 0);
    endtask

    task automatic t_hold_asleep();
        half_ns = 16;
        for (int i = 0; i < 6; i++) begin
            repeat (WIN) @(negedge clk);
            check(active == 0, "R7 mid rate keeps asleep", active, 0);
        end
        half_ns = 0;
        repeat (3 * WIN) @(negedge clk);
    endtask

    task automatic t_burst();
        bit woke = 0;
        half_ns = 8;
        repeat (WIN) @(negedge clk);
        half_ns = 0;
        for (int i = 0; i < 6 * WIN; i++) begin
            @(negedge clk);
            if (active) woke = 1;
        end
        check(!woke, "R5 burst ignored", woke, 0);
    endtask

    task automatic t_run_cleared();
        bit woke = 0;
        int lat;
        half_ns = 8;
        for (int i = 0; i < 2 * WIN; i++) begin @(negedge clk); if (active) woke = 1; end
        half_ns = 16;
        for (int i = 0; i < 2 * WIN + 8; i++) begin @(negedge clk); if (active) woke = 1; end
        check(!woke, "R7 partial run no wake", woke, 0);
        half_ns = 8;
        wait_level(1'b1, 1000, lat);
        t_rise = cyc;
        check(lat >= (RUNS - 1) * WIN, "R7 run cleared", lat, (RUNS - 1) * WIN);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_wake();
        t_hold_awake();
        t_sleep(0, 1'b0, "R6 stopped low sleeps");
        t_hold_asleep();
        t_burst();
        t_wake();
        t_sleep(0, 1'b1, "R3 held high counts zero");
        hold_high = 1'b0;
        t_run_cleared();
        t_sleep(80, 1'b0, "R6 slow clock sleeps");
        #3;
        t_wake();
        t_sleep(0, 1'b0, "R6 phase-shifted stop");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule